// File: doc/BRIEF.md
# Offset-Based Seconds Clock with Byte Command Port

This block keeps a 32-bit count of seconds since midnight at the start of 1 January 1904. It does not keep a settable time counter. A free-running uptime counter is advanced by a prescaler that divides the system clock down to one-second steps. A stored 32-bit offset is added to the uptime counter, and the sum, with wrapping arithmetic, is the current time. At reset the offset is loaded from a 1970-based seconds value on an input pin, shifted to the 1904 epoch by adding 2082844800.

A host drives commands one byte at a time:

- A read command takes no argument bytes. It returns the current time as four response bytes on consecutive cycles, most significant byte first.
- A set command takes four argument bytes, assembled most significant byte first. It recomputes the offset so that the clock shows exactly the given value from the next cycle on.
- A command with the wrong number of argument bytes is refused with a one-cycle reject pulse and changes nothing.

The block also emits a one-cycle tick on every second boundary. A separate interrupt block uses this tick.

Top module: `epoch_seconds_clock`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `time_now` equals `init_unix + 2082844800` modulo 2^32. In that same window `tick`, `rsp_valid`, `rsp_last` and `reject` are low.
- R2: Every `CLK_PER_SEC` cycles, counted from reset, `time_now` rises by exactly 1 and `tick` is high for exactly that one cycle. Apart from a set command, `time_now` changes at no other time, so the tick period never drifts.
- R3: A read command (`cmd_op` = 0) with zero argument bytes produces four response bytes on `rsp_byte`. `rsp_valid` is high on the four cycles that start one cycle after the `cmd_end` cycle. The bytes are bits 31:24, 23:16, 15:8 and 7:0 of `time_now` as it stood in the `cmd_end` cycle, in that order. `rsp_last` is high only with the fourth byte.
- R4: A set command (`cmd_op` = 1) with exactly four argument bytes makes `time_now` equal those bytes from the cycle after `cmd_end` onward, with the first byte sent placed in bits 31:24. After that the time keeps advancing under R2.
- R5: A read command with any argument bytes, or a set command with a byte count other than four, pulses `reject` for one cycle, one cycle after `cmd_end`. Such a command leaves `time_now` and the offset unchanged and produces no response bytes.
- R6: If a set command ends in the same cycle in which a second boundary is crossed, `time_now` on the next cycle equals the set value exactly, and `tick` still pulses.
- R7: The time wraps from 0xFFFFFFFF to 0x00000000 on the next second boundary.
- R8: A `cmd_start` while a command is still collecting discards the earlier opcode and argument bytes and begins a new command. In one cycle, `cmd_end` takes priority over `cmd_start`, and `cmd_start` takes priority over `arg_valid`. `arg_valid` and `cmd_end` are ignored when no command is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_unix | input | 32 | 1970-based seconds; sampled while `rst` is high |
| cmd_start | input | 1 | Opens a command; `cmd_op` is sampled in the same cycle |
| cmd_op | input | 1 | 0 = read time, 1 = set time |
| arg_valid | input | 1 | `arg_byte` holds an argument byte |
| arg_byte | input | 8 | Argument byte, most significant first |
| cmd_end | input | 1 | Closes the open command and executes it |
| time_now | output | 32 | Current 1904-based seconds |
| tick | output | 1 | One-cycle pulse per elapsed second |
| rsp_valid | output | 1 | `rsp_byte` holds a response byte |
| rsp_byte | output | 8 | Response byte |
| rsp_last | output | 1 | Marks the final response byte |
| reject | output | 1 | One-cycle pulse for a command of wrong length |

## Verification
The bound checker watches several properties on every cycle:

- The uptime counter moves only when a tick occurs, and then by exactly one.
- Ticks are single-cycle pulses.
- A rejected command never disturbs the offset.
- An accepted set lands its exact value on the following cycle.
- A response burst, once started, runs unbroken to its last byte.

Only the bench's scenarios can show the exact tick spacing, the byte order and value of a read response, and the 1904 shift at reset. The same holds for the wrap past 0xFFFFFFFF, the restart of a partly sent command, and a set landing on a second boundary. For these the bench compares against its own reference model on every clock and adds explicit scenario checks.

// File: rtl/esc_pkg.sv
package esc_pkg;

    localparam int BYTE_W = 8;
    localparam int TIME_W = 32;
    localparam int NBYTES = TIME_W / BYTE_W;
    localparam logic [TIME_W-1:0] EPOCH_SHIFT = 32'd2082844800;

    typedef logic [TIME_W-1:0] secs_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        OP_READ = 1'b0,
        OP_SET  = 1'b1
    } op_e;

    // Outcome of a closed command
    typedef struct packed {
        logic read_ok;
        logic set_ok;
        logic bad_len;
    } verdict_t;

    function automatic byte_t high_byte(secs_t v);
        return v[TIME_W-1 -: BYTE_W];
    endfunction

    function automatic secs_t to_1904(secs_t unix_secs);
        return unix_secs + EPOCH_SHIFT;
    endfunction

endpackage

// File: rtl/esc_second_gen.sv
module esc_second_gen
    import esc_pkg::*;
#(
    parameter int CLK_PER_SEC = 200_000_000
) (
    input  logic  clk,
    input  logic  rst,
    output secs_t up_sec,
    output secs_t up_next,
    output logic  tick
);
    localparam int PW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_SEC - 1);

    logic [PW-1:0] phase;
    logic          boundary;

    // Fixed-modulus divider: every second is exactly CLK_PER_SEC cycles
    assign boundary = (phase == LAST);
    assign up_next  = boundary ? up_sec + 1'b1 : up_sec;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            up_sec <= '0;
            tick   <= 1'b0;
        end else begin
            phase  <= boundary ? '0 : phase + 1'b1;
            up_sec <= up_next;
            tick   <= boundary;
        end
    end
endmodule

// File: rtl/esc_cmd_collect.sv
module esc_cmd_collect
    import esc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_start,
    input  logic     cmd_op,
    input  logic     arg_valid,
    input  byte_t    arg_byte,
    input  logic     cmd_end,
    output verdict_t verdict,
    output secs_t    arg_word
);
    localparam int CW = $clog2(NBYTES + 2);
    localparam logic [CW-1:0] CNT_MAX = CW'(NBYTES + 1);
    localparam logic [CW-1:0] CNT_SET = CW'(NBYTES);

    logic          open_q;
    op_e           op_q;
    logic [CW-1:0] cnt_q;
    secs_t         word_q;
    logic          closing;

    assign closing  = cmd_end && open_q;
    assign arg_word = word_q;

    always_comb begin
        verdict = '0;
        if (closing) begin
            verdict.read_ok = (op_q == OP_READ) && (cnt_q == '0);
            verdict.set_ok  = (op_q == OP_SET)  && (cnt_q == CNT_SET);
            verdict.bad_len = !verdict.read_ok && !verdict.set_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            op_q   <= OP_READ;
            cnt_q  <= '0;
            word_q <= '0;
        end else if (closing) begin
            open_q <= 1'b0;
        end else if (cmd_start) begin
            open_q <= 1'b1;
            op_q   <= op_e'(cmd_op);
            cnt_q  <= '0;
            word_q <= '0;
        end else if (arg_valid && open_q) begin
            word_q <= {word_q[TIME_W-BYTE_W-1:0], arg_byte};
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/esc_rsp_shift.sv
module esc_rsp_shift
    import esc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  secs_t word,
    output logic  rsp_valid,
    output byte_t rsp_byte,
    output logic  rsp_last
);
    localparam int RW = (NBYTES > 2) ? $clog2(NBYTES) : 1;
    localparam logic [RW-1:0] REM_INIT = RW'(NBYTES - 1);

    secs_t         pend_q;
    logic [RW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            rem_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
            rsp_last  <= 1'b0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_byte  <= high_byte(word);
            pend_q    <= word << BYTE_W;
            rem_q     <= REM_INIT;
            rsp_last  <= (NBYTES == 1);
        end else if (rem_q != '0) begin
            rsp_valid <= 1'b1;
            rsp_byte  <= high_byte(pend_q);
            pend_q    <= pend_q << BYTE_W;
            rem_q     <= rem_q - 1'b1;
            rsp_last  <= (rem_q == RW'(1));
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
        end
    end
endmodule

// File: rtl/epoch_seconds_clock.sv
module epoch_seconds_clock
    import esc_pkg::*;
#(
    parameter int CLK_PER_SEC = 200_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] init_unix,
    input  logic        cmd_start,
    input  logic        cmd_op,
    input  logic        arg_valid,
    input  logic [7:0]  arg_byte,
    input  logic        cmd_end,
    output logic [31:0] time_now,
    output logic        tick,
    output logic        rsp_valid,
    output logic [7:0]  rsp_byte,
    output logic        rsp_last,
    output logic        reject
);
    secs_t    up_sec;
    secs_t    up_next;
    secs_t    offset;
    secs_t    arg_word;
    verdict_t verd;

    esc_second_gen #(.CLK_PER_SEC(CLK_PER_SEC)) u_sec (
        .clk     (clk),
        .rst     (rst),
        .up_sec  (up_sec),
        .up_next (up_next),
        .tick    (tick)
    );

    esc_cmd_collect u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .arg_valid (arg_valid),
        .arg_byte  (arg_byte),
        .cmd_end   (cmd_end),
        .verdict   (verd),
        .arg_word  (arg_word)
    );

    assign time_now = up_sec + offset;

    // Offset is taken against the uptime of the next cycle, so a set
    // coinciding with a second boundary still lands exactly.
    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= to_1904(init_unix);
            reject <= 1'b0;
        end else begin
            if (verd.set_ok) begin
                offset <= arg_word - up_next;
            end
            reject <= verd.bad_len;
        end
    end

    esc_rsp_shift u_rsp (
        .clk       (clk),
        .rst       (rst),
        .load      (verd.read_ok),
        .word      (time_now),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte),
        .rsp_last  (rsp_last)
    );
endmodule

// File: rtl/esc_checker.sv
module esc_checker
    import esc_pkg::*;
#(
    parameter int CLK_PER_SEC = 200_000_000
) (
    input logic  clk,
    input logic  rst,
    input logic  tick,
    input secs_t up_sec,
    input secs_t offset,
    input secs_t time_now,
    input logic  reject,
    input logic  rsp_valid,
    input logic  rsp_last,
    input logic  set_fire,
    input secs_t set_word
);
    p_tick_bump_r2: assert property (@(posedge clk) disable iff (rst)
        tick |-> up_sec == $past(up_sec) + 1'b1);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |-> $stable(up_sec));

    p_tick_short_r2: assert property (@(posedge clk) disable iff (rst || CLK_PER_SEC < 2)
        tick |=> !tick);

    p_set_lands_r4: assert property (@(posedge clk) disable iff (rst)
        set_fire |=> time_now == $past(set_word));   // also R6 on a boundary

    p_reject_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        reject |-> $stable(offset));

    p_burst_runs_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_last) |=> rsp_valid);

    p_last_in_burst_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);
endmodule

bind epoch_seconds_clock esc_checker #(.CLK_PER_SEC(CLK_PER_SEC)) u_esc_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .up_sec    (up_sec),
    .offset    (offset),
    .time_now  (time_now),
    .reject    (reject),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .set_fire  (verd.set_ok),
    .set_word  (arg_word)
);

// File: tb/epoch_seconds_clock_test.sv
`timescale 1ns/1ps
module epoch_seconds_clock_test;
    localparam int DIV = 8;
    localparam logic [31:0] INIT = 32'h6000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] init_unix = INIT;
    logic        cmd_start = 1'b0, cmd_op = 1'b0, arg_valid = 1'b0, cmd_end = 1'b0;
    logic [7:0]  arg_byte = '0;
    logic [31:0] time_now;
    logic        tick, rsp_valid, rsp_last, reject;
    logic [7:0]  rsp_byte;

    int checks = 0;
    int errors = 0;
    bit live = 0;

    always #2.5 clk = ~clk;

    epoch_seconds_clock #(.CLK_PER_SEC(DIV)) uut (
        .clk(clk), .rst(rst), .init_unix(init_unix),
        .cmd_start(cmd_start), .cmd_op(cmd_op), .arg_valid(arg_valid),
        .arg_byte(arg_byte), .cmd_end(cmd_end), .time_now(time_now),
        .tick(tick), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .rsp_last(rsp_last), .reject(reject)
    );

    // ---------------- behavioural reference model ----------------
    int          m_pre;
    logic [31:0] m_up, m_off, m_asm;
    int          m_cnt;
    bit          m_open, m_op, m_tick, m_rej, m_rv, m_last;
    logic [7:0]  m_rb;
    logic [7:0]  m_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_up = 0; m_off = init_unix + 32'd2082844800;
            m_open = 0; m_op = 0; m_cnt = 0; m_asm = 0;
            m_tick = 0; m_rej = 0; m_rv = 0; m_last = 0; m_rb = 0;
            m_q.delete();
        end else begin
            bit wrap, rd, st, bad;
            logic [31:0] up_nx, cur;
            wrap = (m_pre == DIV - 1);
            up_nx = m_up + (wrap ? 32'd1 : 32'd0);
            cur = m_up + m_off;
            rd = 0; st = 0; bad = 0;
            if (cmd_end && m_open) begin
                m_open = 0;
                if (m_op == 0 && m_cnt == 0) rd = 1;
                else if (m_op == 1 && m_cnt == 4) st = 1;
                else bad = 1;
            end else if (cmd_start) begin
                m_open = 1; m_op = cmd_op; m_cnt = 0; m_asm = 0;
            end else if (arg_valid && m_open) begin
                m_asm = {m_asm[23:0], arg_byte};
                m_cnt++;
            end
            if (st) m_off = m_asm - up_nx;
            if (rd) for (int k = 3; k >= 0; k--) m_q.push_back(cur[8*k +: 8]);
            if (m_q.size() > 0) begin
                m_rv = 1; m_rb = m_q.pop_front(); m_last = (m_q.size() == 0);
            end else begin
                m_rv = 0; m_last = 0;
            end
            m_rej = bad;
            m_tick = wrap;
            m_pre = wrap ? 0 : m_pre + 1;
            m_up = up_nx;
        end
    end

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (live && !rst) begin
            check32("R2 time_now vs model", time_now, m_up + m_off);
            check32("R2 tick vs model", {31'd0, tick}, {31'd0, m_tick});
            check32("R5 reject vs model", {31'd0, reject}, {31'd0, m_rej});
            check32("R3 rsp_valid vs model", {31'd0, rsp_valid}, {31'd0, m_rv});
            if (m_rv) begin
                check32("R3 rsp_byte vs model", {24'd0, rsp_byte}, {24'd0, m_rb});
                check32("R3 rsp_last vs model", {31'd0, rsp_last}, {31'd0, m_last});
            end
        end
    end

    // ---------------- stimulus tasks (entered just after a negedge) ----------------
    logic [31:0] t_before;

    task automatic begin_cmd(bit op);
        cmd_start = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic push_args(int n, logic [39:0] bytes);
        for (int i = 0; i < n; i++) begin
            arg_valid = 1'b1;
            arg_byte  = bytes[39 - 8*i -: 8];
            @(negedge clk);
        end
        arg_valid = 1'b0;
    endtask

    task automatic end_cmd();
        t_before = time_now;
        cmd_end = 1'b1;
        @(negedge clk);
        cmd_end = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] got;
        int seen;
        idle(3);
        // R1: reset state, sampled during reset
        check32("R1 time during reset", time_now, INIT + 32'd2082844800);
        check32("R1 outputs low during reset", {28'd0, tick, rsp_valid, rsp_last, reject}, 32'd0);
        rst = 1'b0;
        live = 1;
        @(negedge clk);
        check32("R1 time after reset", time_now, INIT + 32'd2082844800);
        check32("R1 outputs low after reset", {28'd0, tick, rsp_valid, rsp_last, reject}, 32'd0);

        // R2: count cycles between ticks
        while (!tick) @(negedge clk);
        got = time_now;
        seen = 0;
        @(negedge clk);
        while (!tick) begin seen++; @(negedge clk); end
        check32("R2 tick spacing", seen + 1, DIV);
        check32("R2 step of one", time_now, got + 1);

        // R3: read command
        begin_cmd(1'b0);
        idle(2);
        end_cmd();
        got = 0;
        for (int i = 0; i < 4; i++) begin
            check32("R3 rsp_valid in burst", {31'd0, rsp_valid}, 32'd1);
            check32("R3 rsp_last position", {31'd0, rsp_last}, {31'd0, i == 3});
            got = {got[23:0], rsp_byte};
            @(negedge clk);
        end
        check32("R3 read value MSB first", got, t_before);
        check32("R3 burst ends", {31'd0, rsp_valid}, 32'd0);

        // R4: set command
        begin_cmd(1'b1);
        push_args(4, 40'h12345678_00);
        end_cmd();
        check32("R4 set value visible", time_now, 32'h12345678);
        idle(DIV + 1);
        check32("R4 advances after set", time_now, 32'h12345679);

        // R5: wrong lengths
        got = time_now;
        begin_cmd(1'b0);
        push_args(1, 40'hAA_00000000);
        end_cmd();
        check32("R5 read with arg rejected", {31'd0, reject}, 32'd1);
        check32("R5 no response", {31'd0, rsp_valid}, 32'd0);
        begin_cmd(1'b1);
        push_args(3, 40'h010203_0000);
        end_cmd();
        check32("R5 set with 3 args rejected", {31'd0, reject}, 32'd1);
        begin_cmd(1'b1);
        push_args(5, 40'h0102030405);
        end_cmd();
        check32("R5 set with 5 args rejected", {31'd0, reject}, 32'd1);
        check32("R5 time unchanged by rejects", time_now - got <= 32'd3 ? 32'd1 : 32'd0, 32'd1);
        check32("R5 offset intact vs model", time_now, m_up + m_off);

        // R6: set ending on a second boundary
        begin_cmd(1'b1);
        push_args(4, 40'hCAFEF00D_00);
        while (m_pre != DIV - 1) @(negedge clk);
        end_cmd();
        check32("R6 tick on set cycle", {31'd0, tick}, 32'd1);
        check32("R6 set value exact", time_now, 32'hCAFEF00D);

        // R7: wrap
        begin_cmd(1'b1);
        push_args(4, 40'hFFFFFFFE_00);
        end_cmd();
        seen = 0;
        while (seen < 2) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check32("R7 wrap to zero", time_now, 32'h0000_0000);

        // R8: restart discards partial command
        begin_cmd(1'b1);
        push_args(2, 40'h9999_000000);
        begin_cmd(1'b1);
        push_args(4, 40'h00ABCDEF_00);
        end_cmd();
        check32("R8 restart keeps new value", time_now, 32'h00ABCDEF);
        check32("R8 no reject after restart", {31'd0, reject}, 32'd0);
        arg_valid = 1'b1; arg_byte = 8'h55;
        @(negedge clk);
        arg_valid = 1'b0;
        cmd_end = 1'b1;
        @(negedge clk);
        cmd_end = 1'b0;
        check32("R8 stray end ignored", {30'd0, reject, rsp_valid}, 32'd0);

        idle(3 * DIV);
        live = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule